// File: doc/BRIEF.md
# Receive Signaling Serial Output Formatter

This block turns per-channel signaling nibbles, already extracted by a T1 or E1 receive framer, into a one-bit serial signaling stream. The stream is aligned to the recovered line clock, which runs at 1.544 MHz for T1 and 2.048 MHz for E1. It is also aligned to the frame, timeslot and bit counters that the framer supplies. A host-writable store keeps four signaling bits (A, B, C, D) for each of 32 channels. Each timeslot takes a snapshot of the nibble it needs, so a store update in the middle of a timeslot never splits one nibble across two values.

Where the bits land depends on the selected controls. In T1 mode, and in the per-timeslot E1 mode, a channel's bits sit in the upper half of its own timeslot. The code-size select trims them to one, two or four bits. In the E1 CAS mode all signaling moves into timeslot 16. Frames 1 to 15 carry two channels each. Frame 0 carries the multiframe alignment zeros and the spare and alarm bits. When the interface is disabled, the output stays low.

The block runs on a fast system clock. A one-cycle line clock enable marks each line bit. The framer presents the position of that bit together with the enable.

Top module: `rsig_serial_fmt`

## Requirements
- R1: While `en` is low at the bit's enable cycle, `sig_out` for that bit is 0.
- R2: T1 mode (`e1_mode`=0) with `code_sel`=2 or 3 (16-code) places nibble bits A, B, C, D (nibble bits 3, 2, 1, 0) at bit positions 4, 5, 6, 7 of timeslot n, taken from store entry n. Positions 0 to 3 are 0.
- R3: T1 mode with `code_sel`=1 (4-code) outputs A at position 4 and B at position 5. Positions 6 and 7 are 0.
- R4: T1 mode with `code_sel`=0 (2-code) outputs only A, at position 4. Every other position is 0.
- R5: In T1 mode, the output is 0 during the framing bit (`frame_bit`=1) and in any timeslot numbered 24 or above.
- R6: E1 mode with `ts16_only`=0 uses the same per-timeslot placement and code-size trimming as T1, over timeslots 0 to 31.
- R7: E1 mode with `ts16_only`=1, frame k from 1 to 15, timeslot 16: positions 0 to 3 carry store entry k (A first) and positions 4 to 7 carry store entry k+16 (A first).
- R8: E1 mode with `ts16_only`=1, frame 0, timeslot 16: positions 0 to 3 are 0 and positions 4 to 7 carry `spare_bits[3]`, `[2]`, `[1]`, `[0]` in that order.
- R9: E1 mode with `ts16_only`=1: every timeslot other than 16 outputs 0.
- R10: Store entries and `spare_bits` are sampled once, at bit position 0 of each timeslot. Writes or spare changes later in the same timeslot do not alter that timeslot's output.
- R11: `sig_out` for the position presented with `lce` changes on the second rising clock edge after that enable cycle. It holds its old value after the first edge.
- R12: During and right after reset, `sig_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lce | input | 1 | Line bit enable, one cycle per line bit |
| en | input | 1 | Signaling interface enable |
| e1_mode | input | 1 | 1 = E1 framing, 0 = T1 framing |
| ts16_only | input | 1 | E1 only: 1 = all signaling in timeslot 16 |
| code_sel | input | 2 | 0 = 2-code, 1 = 4-code, 2 or 3 = 16-code |
| frame_idx | input | 4 | Frame number within the multiframe |
| slot_idx | input | 5 | Timeslot number |
| bit_idx | input | 3 | Bit position in the timeslot, 0 sent first |
| frame_bit | input | 1 | T1 framing bit marker |
| spare_bits | input | 4 | E1 x, y, x, x spare and alarm bits |
| wr_en | input | 1 | Store write strobe |
| wr_ch | input | 5 | Store channel to write |
| wr_nib | input | 4 | Nibble to write, A in bit 3 |
| sig_out | output | 1 | Serial signaling output |

## Verification
Each line bit yields its output two clock edges after the enable cycle: one edge for the position register and the store read, one for the output register. The bench holds each line bit for three cycles. It checks after the first edge that the output still shows the previous bit (R11), and after the second edge that it shows the new one. Store writes are issued only while the enable is low, in the middle of a timeslot, so the bench model snapshots store and spare values at the same point as the design.

// File: rtl/rsig_pkg.sv
package rsig_pkg;
  localparam int SLOT_W = 5;
  localparam int BIT_W  = 3;
  localparam int FRM_W  = 4;
  localparam int NIB_W  = 4;
  localparam int BANK_AW = SLOT_W - 1;

  typedef enum logic [1:0] {
    CODE_TWO     = 2'd0,
    CODE_FOUR    = 2'd1,
    CODE_SIXTEEN = 2'd2,
    CODE_SIXTEEN_ALT = 2'd3
  } code_e;

  typedef struct packed {
    logic              en;
    logic              e1;
    logic              ts16;
    code_e             code;
    logic              fbit;
    logic [FRM_W-1:0]  frame;
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bitp;
    logic [NIB_W-1:0]  spare;
  } pos_t;
endpackage

// File: rtl/rsig_bank.sv
module rsig_bank #(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read with enable: the output register doubles as the
  // per-timeslot snapshot.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rsig_store.sv
module rsig_store
  import rsig_pkg::*;
#(
  parameter int NBANK = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_ch,
  input  logic [NIB_W-1:0]   wr_nib,
  input  logic               rd_en,
  input  logic [BANK_AW-1:0] rd_addr,
  output logic [NIB_W-1:0]   rd_nib [NBANK]
);
  localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [BSEL_W-1:0] wr_bank;
  assign wr_bank = BSEL_W'(wr_ch >> BANK_AW);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    rsig_bank #(.AW(BANK_AW), .DW(NIB_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en && (wr_bank == BSEL_W'(b))),
      .waddr (wr_ch[BANK_AW-1:0]),
      .wdata (wr_nib),
      .re    (rd_en),
      .raddr (rd_addr),
      .rdata (rd_nib[b])
    );
  end
endmodule

// File: rtl/rsig_capture.sv
module rsig_capture
  import rsig_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               lce,
  input  logic               en,
  input  logic               e1_mode,
  input  logic               ts16_only,
  input  logic [1:0]         code_sel,
  input  logic [FRM_W-1:0]   frame_idx,
  input  logic [SLOT_W-1:0]  slot_idx,
  input  logic [BIT_W-1:0]   bit_idx,
  input  logic               frame_bit,
  input  logic [NIB_W-1:0]   spare_bits,
  output logic               rd_en,
  output logic [BANK_AW-1:0] rd_addr,
  output pos_t               pos_q
);
  logic slot_start;
  assign slot_start = lce && (bit_idx == '0);

  // CAS mode reads the channel pair for this frame; otherwise the
  // pair sharing this timeslot's low address bits.
  assign rd_en   = slot_start;
  assign rd_addr = (e1_mode && ts16_only) ? BANK_AW'(frame_idx)
                                          : slot_idx[BANK_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (lce) begin
      pos_q.en    <= en;
      pos_q.e1    <= e1_mode;
      pos_q.ts16  <= ts16_only;
      pos_q.code  <= code_e'(code_sel);
      pos_q.fbit  <= frame_bit;
      pos_q.frame <= frame_idx;
      pos_q.slot  <= slot_idx;
      pos_q.bitp  <= bit_idx;
      if (slot_start) pos_q.spare <= spare_bits;
    end
  end
endmodule

// File: rtl/rsig_pick.sv
module rsig_pick
  import rsig_pkg::*;
#(
  parameter int T1_SLOTS  = 24,
  parameter int CAS_SLOT  = 16,
  parameter int SIG_BIT0  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  pos_t             pos_q,
  input  logic [NIB_W-1:0] nib_lo,
  input  logic [NIB_W-1:0] nib_hi,
  output logic             sig_out
);
  localparam logic [SLOT_W-1:0] T1_LIM  = SLOT_W'(T1_SLOTS);
  localparam logic [SLOT_W-1:0] CAS_TS  = SLOT_W'(CAS_SLOT);
  localparam logic [BIT_W-1:0]  UPPER0  = BIT_W'(SIG_BIT0);
  localparam int                OFF_W   = $clog2(NIB_W);

  logic             upper;
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] idx;
  logic [2:0]       depth;
  logic [NIB_W-1:0] own_nib;
  logic             slot_bit;
  logic             cas_bit;
  logic             nxt;

  assign upper   = (pos_q.bitp >= UPPER0);
  assign off     = pos_q.bitp[OFF_W-1:0];
  assign idx     = OFF_W'(NIB_W - 1) - off;
  assign own_nib = pos_q.slot[SLOT_W-1] ? nib_hi : nib_lo;

  always_comb begin
    unique case (pos_q.code)
      CODE_TWO:  depth = 3'd1;
      CODE_FOUR: depth = 3'd2;
      default:   depth = 3'd4;
    endcase
  end

  assign slot_bit = upper && ({1'b0, off} < depth) && own_nib[idx];

  always_comb begin
    cas_bit = 1'b0;
    if (pos_q.slot == CAS_TS) begin
      if (pos_q.frame == '0) cas_bit = upper && pos_q.spare[idx];
      else                   cas_bit = upper ? nib_hi[idx] : nib_lo[idx];
    end
  end

  always_comb begin
    nxt = 1'b0;
    if (pos_q.en) begin
      if (!pos_q.e1)       nxt = !pos_q.fbit && (pos_q.slot < T1_LIM) && slot_bit;
      else if (pos_q.ts16) nxt = cas_bit;
      else                 nxt = slot_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sig_out <= 1'b0;
    else     sig_out <= nxt;
  end
endmodule

// File: rtl/rsig_serial_fmt.sv
module rsig_serial_fmt
  import rsig_pkg::*;
#(
  parameter int T1_SLOTS = 24,
  parameter int CAS_SLOT = 16,
  parameter int SIG_BIT0 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lce,
  input  logic              en,
  input  logic              e1_mode,
  input  logic              ts16_only,
  input  logic [1:0]        code_sel,
  input  logic [FRM_W-1:0]  frame_idx,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              frame_bit,
  input  logic [NIB_W-1:0]  spare_bits,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_ch,
  input  logic [NIB_W-1:0]  wr_nib,
  output logic              sig_out
);
  localparam int NBANK = 2;

  pos_t               pos_q;
  logic               rd_en;
  logic [BANK_AW-1:0] rd_addr;
  logic [NIB_W-1:0]   rd_nib [NBANK];
  logic [NIB_W-1:0]   rd_lo;
  logic [NIB_W-1:0]   rd_hi;

  rsig_capture u_cap (
    .clk        (clk),
    .rst        (rst),
    .lce        (lce),
    .en         (en),
    .e1_mode    (e1_mode),
    .ts16_only  (ts16_only),
    .code_sel   (code_sel),
    .frame_idx  (frame_idx),
    .slot_idx   (slot_idx),
    .bit_idx    (bit_idx),
    .frame_bit  (frame_bit),
    .spare_bits (spare_bits),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .pos_q      (pos_q)
  );

  rsig_store #(.NBANK(NBANK)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_ch   (wr_ch),
    .wr_nib  (wr_nib),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_nib  (rd_nib)
  );

  assign rd_lo = rd_nib[0];
  assign rd_hi = rd_nib[1];

  rsig_pick #(
    .T1_SLOTS (T1_SLOTS),
    .CAS_SLOT (CAS_SLOT),
    .SIG_BIT0 (SIG_BIT0)
  ) u_pick (
    .clk     (clk),
    .rst     (rst),
    .pos_q   (pos_q),
    .nib_lo  (rd_lo),
    .nib_hi  (rd_hi),
    .sig_out (sig_out)
  );
endmodule

// File: rtl/rsig_chk.sv
module rsig_chk
  import rsig_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              lce,
  input logic              en,
  input logic              e1_mode,
  input logic              ts16_only,
  input logic [1:0]        code_sel,
  input logic [FRM_W-1:0]  frame_idx,
  input logic [SLOT_W-1:0] slot_idx,
  input logic [BIT_W-1:0]  bit_idx,
  input logic              frame_bit,
  input logic              sig_out,
  input logic [NIB_W-1:0]  rd_lo,
  input logic [NIB_W-1:0]  rd_hi
);
  assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
    (lce && !en) |-> ##2 (sig_out == 1'b0));

  assert_two_code_only_a_R4: assert property (@(posedge clk) disable iff (rst)
    (lce && en && !e1_mode && code_sel == 2'd0 && bit_idx != 3'd4) |-> ##2 (sig_out == 1'b0));

  assert_frame_bit_low_R5: assert property (@(posedge clk) disable iff (rst)
    (lce && en && !e1_mode && frame_bit) |-> ##2 (sig_out == 1'b0));

  assert_align_zeros_R8: assert property (@(posedge clk) disable iff (rst)
    (lce && en && e1_mode && ts16_only && slot_idx == 5'd16 && frame_idx == '0 && bit_idx < 3'd4)
      |-> ##2 (sig_out == 1'b0));

  assert_other_slots_low_R9: assert property (@(posedge clk) disable iff (rst)
    (lce && en && e1_mode && ts16_only && slot_idx != 5'd16) |-> ##2 (sig_out == 1'b0));

  assert_snapshot_held_R10: assert property (@(posedge clk) disable iff (rst)
    !(lce && bit_idx == '0) |=> ($stable(rd_lo) && $stable(rd_hi)));

  assert_reset_low_R12: assert property (@(posedge clk)
    rst |=> (sig_out == 1'b0));
endmodule

bind rsig_serial_fmt rsig_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .lce       (lce),
  .en        (en),
  .e1_mode   (e1_mode),
  .ts16_only (ts16_only),
  .code_sel  (code_sel),
  .frame_idx (frame_idx),
  .slot_idx  (slot_idx),
  .bit_idx   (bit_idx),
  .frame_bit (frame_bit),
  .sig_out   (sig_out),
  .rd_lo     (rd_lo),
  .rd_hi     (rd_hi)
);

// File: tb/rsig_serial_fmt_tb.sv
module rsig_serial_fmt_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       lce, en, e1_mode, ts16_only, frame_bit, wr_en;
  logic [1:0] code_sel;
  logic [3:0] frame_idx, spare_bits, wr_nib;
  logic [4:0] slot_idx, wr_ch;
  logic [2:0] bit_idx;
  logic       sig_out;

  always #4 clk = ~clk;

  rsig_serial_fmt u_dut (
    .clk(clk), .rst(rst), .lce(lce), .en(en), .e1_mode(e1_mode),
    .ts16_only(ts16_only), .code_sel(code_sel), .frame_idx(frame_idx),
    .slot_idx(slot_idx), .bit_idx(bit_idx), .frame_bit(frame_bit),
    .spare_bits(spare_bits), .wr_en(wr_en), .wr_ch(wr_ch), .wr_nib(wr_nib),
    .sig_out(sig_out)
  );

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  logic [3:0] mem_m [32];
  logic [3:0] sn_lo, sn_hi, sn_sp;
  logic       prev_exp = 1'b0;
  bit         tore = 1'b0;

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic per_slot(input logic [3:0] nib, input int b, input logic [1:0] c);
    int depth;
    depth = (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    if (b < 4 || (b - 4) >= depth) return 1'b0;
    return nib[7 - b];
  endfunction

  function automatic void exp_of(input int fr, input int sl, input int b, input bit fb,
                                 output logic v, output string t);
    logic [3:0] own;
    own = (sl >= 16) ? sn_hi : sn_lo;
    v = 1'b0;
    if (!en) t = "R1";
    else if (!e1_mode) begin
      if (fb || sl >= 24) t = "R5";
      else begin
        t = (code_sel == 2'd0) ? "R4" : (code_sel == 2'd1) ? "R3" : "R2";
        v = per_slot(own, b, code_sel);
      end
    end else if (ts16_only) begin
      if (sl != 16) t = "R9";
      else if (fr == 0) begin t = "R8"; v = (b < 4) ? 1'b0 : sn_sp[7 - b]; end
      else begin t = "R7"; v = (b < 4) ? sn_lo[3 - b] : sn_hi[7 - b]; end
    end else begin
      t = "R6";
      v = per_slot(own, b, code_sel);
    end
  endfunction

  task automatic do_bit(input int fr, input int sl, input int b, input bit fb);
    logic  v;
    string t;
    int    a;
    @(negedge clk);
    lce = 1'b1; frame_idx = 4'(fr); slot_idx = 5'(sl); bit_idx = 3'(b); frame_bit = fb;
    if (b == 0) begin
      a = (e1_mode && ts16_only) ? fr : (sl % 16);
      sn_lo = mem_m[a]; sn_hi = mem_m[a + 16]; sn_sp = spare_bits; tore = 1'b0;
    end
    exp_of(fr, sl, b, fb, v, t);
    if (tore) t = {t, "/R10"};
    @(negedge clk);
    lce = 1'b0;
    chk(sig_out, prev_exp, "R11");
    // Mid-slot writes, often aimed at the snapshot channel (R10)
    if (b != 7 && ($urandom % 6) == 0) begin
      a = ($urandom % 2 == 0) ? (((e1_mode && ts16_only) ? fr : (sl % 16)) + 16 * ($urandom % 2))
                             : int'($urandom % 32);
      wr_ch = 5'(a); wr_nib = 4'($urandom); wr_en = 1'b1;
      mem_m[a] = wr_nib; tore = 1'b1;
      spare_bits = 4'($urandom);
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk(sig_out, v, t);
    prev_exp = v;
  endtask

  task automatic run_frame(input int fr);
    if (!e1_mode) begin
      do_bit(fr, 31, 7, 1'b1);
      for (int s = 0; s < 24; s++)
        for (int b = 0; b < 8; b++) do_bit(fr, s, b, 1'b0);
    end else begin
      for (int s = 0; s < 32; s++)
        for (int b = 0; b < 8; b++) do_bit(fr, s, b, 1'b0);
    end
  endtask

  task automatic fill_store();
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_ch = 5'(c); wr_nib = 4'($urandom); mem_m[c] = wr_nib;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cfg(input bit e, input bit m, input bit t16, input logic [1:0] c);
    @(negedge clk);
    en = e; e1_mode = m; ts16_only = t16; code_sel = c;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; lce = 1'b0; en = 1'b0; e1_mode = 1'b0; ts16_only = 1'b0; code_sel = 2'd2;
    frame_idx = '0; slot_idx = '0; bit_idx = '0; frame_bit = 1'b0; spare_bits = 4'b1011;
    wr_en = 1'b0; wr_ch = '0; wr_nib = '0;
    repeat (3) @(negedge clk);
    chk(sig_out, 1'b0, "R12");
    rst = 1'b0;
    @(negedge clk);
    chk(sig_out, 1'b0, "R12");

    fill_store();
    // Directed corner: all-ones nibble on channel 3 for full-code placement
    @(negedge clk); wr_en = 1'b1; wr_ch = 5'd3; wr_nib = 4'hF; mem_m[3] = 4'hF;
    @(negedge clk); wr_en = 1'b0;

    set_cfg(1, 0, 0, 2'd2); run_frame(0); run_frame(1);
    set_cfg(1, 0, 0, 2'd3); run_frame(2);
    set_cfg(1, 0, 0, 2'd1); run_frame(3);
    set_cfg(1, 0, 0, 2'd0); run_frame(4);
    // T1 positions past the last timeslot stay low (R5)
    set_cfg(1, 0, 0, 2'd2);
    for (int s = 24; s < 26; s++)
      for (int b = 0; b < 8; b++) do_bit(5, s, b, 1'b0);

    set_cfg(1, 1, 0, 2'd2); run_frame(0); run_frame(1);
    set_cfg(1, 1, 0, 2'd0); run_frame(2);
    set_cfg(1, 1, 0, 2'd1); run_frame(3);

    // Directed spare pattern for frame 0 (R8)
    @(negedge clk); spare_bits = 4'b1010;
    set_cfg(1, 1, 1, 2'd2);
    for (int f = 0; f < 16; f++) run_frame(f);

    set_cfg(0, 0, 0, 2'd2); run_frame(0);
    set_cfg(0, 1, 1, 2'd2); run_frame(0); run_frame(1);

    fill_store();
    set_cfg(1, 1, 1, 2'd1);
    for (int f = 0; f < 16; f++) run_frame(f);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule